// File: doc/BRIEF.md
# Dual-Channel IDE Address Mode Decoder

This block is the host-bus front end of a two-channel IDE controller. It holds the controller's identification, status, class/revision and base-address configuration dwords. It lets software move each channel on its own between compatibility addressing and native addressing. In compatibility addressing a channel answers at the fixed legacy I/O ports. In native addressing it answers only through base-address registers that software has programmed.

Each I/O cycle is decoded into at most one select strobe. The possible targets are a channel's command block, a channel's control block, or the shared 16-byte bus-master register window. The strobe comes with the byte offset inside the selected window, so the drive-side state machines and the DMA engine (not part of this block) can act on it. The block also routes the two channel interrupts. A channel in compatibility mode drives its own legacy interrupt line. A channel in native mode drives the shared host-bus interrupt.

Top module: `ide_mode_decoder`

## Requirements
- R1: After reset the configuration dwords read as follows. Dword 0 reads the `DEV_ID` parameter. Dword 1 reads 0x00B00000 (status 0x00B0 in the upper half, command zero). Dword 2 reads {0x01, 0x01, 0x8A, `REV`}, with the mode flags in its byte 1. Dword 8 (bus-master base) reads 0x0000FF61. Dwords 4 to 7 read 0x00000001.
- R2: A write to dword 2 changes only bit 8 (primary mode) and bit 10 (secondary mode), and only when byte enable 1 is set. Every other bit of dword 2 keeps its value.
- R3: With bit 8 of dword 2 clear (compatibility), I/O addresses 0x1F0 to 0x1F7 select the primary command block, and address 0x3F6 selects the primary control block.
- R4: With bit 10 of dword 2 clear, addresses 0x170 to 0x177 select the secondary command block, and 0x376 selects the secondary control block.
- R5: A channel in native mode ignores its legacy addresses. It decodes its command block through an 8-byte window (primary at dword 4, secondary at dword 6) and its control block through a 4-byte window (primary at dword 5, secondary at dword 7). Each such window decodes nothing until its dword has been written.
- R6: The bus-master window is 16 bytes at the base held in dword 8, in either mode. Offsets 0 to 7 belong to the primary channel and offsets 8 to 15 to the secondary channel. The offset is presented on `sel_offset`.
- R7: A select strobe and its offset appear in the cycle after the one in which `io_valid` is high. When `io_valid` is low, no strobe follows. The offset is the address masked to the window size: 4 bits for bus-master, 3 for command, 2 for control.
- R8: At most one strobe is high at a time. When windows overlap, priority runs bus-master, primary command, primary control, secondary command, secondary control. An address that matches no window gives no strobe.
- R9: A channel in compatibility mode passes its interrupt input to its own legacy output. A channel in native mode holds its legacy output low and contributes to `irq_pci`.
- R10: A base-address dword reads back with the bits below the window size cleared and bit 0 set (I/O space). Only bits 15:0 are stored, written by byte enables 0 and 1.
- R11: An I/O access in the same cycle as a mode write is decoded with the mode in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_dw` (combinational) |
| io_valid | input | 1 | I/O cycle present |
| io_addr | input | 16 | I/O address |
| sel_pri_cmd | output | 1 | Primary command block select |
| sel_pri_ctl | output | 1 | Primary control block select |
| sel_sec_cmd | output | 1 | Secondary command block select |
| sel_sec_ctl | output | 1 | Secondary control block select |
| sel_bm | output | 1 | Bus-master window select |
| sel_offset | output | 4 | Byte offset inside the selected window |
| irq_pri_in | input | 1 | Primary channel interrupt request |
| irq_sec_in | input | 1 | Secondary channel interrupt request |
| irq_pri_legacy | output | 1 | Primary legacy interrupt line |
| irq_sec_legacy | output | 1 | Secondary legacy interrupt line |
| irq_pci | output | 1 | Shared interrupt for native-mode channels |

## Verification
A mode write to dword 2 and an I/O access to that channel's legacy command port can arrive in the same clock. The bench drives both in one cycle, switching the primary channel to native while it reads 0x1F2. It expects the primary command strobe with offset 2 from that access, because the mode used is the one before the write. The next access to the same port must then give no strobe. A second overlap puts a native secondary command window on top of the bus-master base, and the bench checks that the bus-master strobe wins.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int NBAR = 5;
  localparam int BAR_PCMD = 0;
  localparam int BAR_PCTL = 1;
  localparam int BAR_SCMD = 2;
  localparam int BAR_SCTL = 3;
  localparam int BAR_BM   = 4;
  localparam int BAR_DW0  = 4;   // first base-address dword index

  // select vector bit positions, highest bit has highest priority
  localparam int SEL_SCTL = 0;
  localparam int SEL_SCMD = 1;
  localparam int SEL_PCTL = 2;
  localparam int SEL_PCMD = 3;
  localparam int SEL_BM   = 4;
  localparam int NSEL     = 5;

  typedef logic [NSEL-1:0] sel_t;
  typedef logic [NBAR-1:0][15:0] bar_arr_t;

  localparam logic [15:0] LEG_PCMD = 16'h01F0;
  localparam logic [15:0] LEG_PCTL = 16'h03F6;
  localparam logic [15:0] LEG_SCMD = 16'h0170;
  localparam logic [15:0] LEG_SCTL = 16'h0376;

  // log2 of each window size
  function automatic int unsigned bar_lg2(input int idx);
    case (idx)
      BAR_PCMD, BAR_SCMD: return 3;
      BAR_PCTL, BAR_SCTL: return 2;
      default:            return 4;
    endcase
  endfunction

  function automatic logic win_hit(input logic [15:0] a, input logic [15:0] base,
                                   input int unsigned lg2);
    return (a >> lg2) == (base >> lg2);
  endfunction

  // keep only the highest-priority hit
  function automatic sel_t pick_one(input sel_t hits);
    sel_t r;
    logic taken;
    r = '0;
    taken = 1'b0;
    for (int i = NSEL - 1; i >= 0; i--) begin
      if (hits[i] && !taken) begin
        r[i]  = 1'b1;
        taken = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] off_mask(input sel_t s);
    if (s[SEL_BM])                    return 4'hF;
    else if (s[SEL_PCMD] || s[SEL_SCMD]) return 4'h7;
    else if (s[SEL_PCTL] || s[SEL_SCTL]) return 4'h3;
    else                              return 4'h0;
  endfunction
endpackage

// File: rtl/ide_cfg_regs.sv
module ide_cfg_regs
  import ide_dec_pkg::*;
#(
  parameter int          CFG_AW      = 6,
  parameter logic [31:0] DEV_ID      = 32'h5A17_1D3C,
  parameter logic [7:0]  REV         = 8'hA3,
  parameter logic [15:0] BM_BASE_RST = 16'hFF60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_dw,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mode_pri,
  output logic              mode_sec,
  output bar_arr_t          bar_base,
  output logic [NBAR-1:0]   bar_ok
);
  localparam logic [CFG_AW-1:0] DW_ID     = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] DW_STAT   = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] DW_CLASS  = CFG_AW'(2);
  localparam logic [7:0]        PI_RESET  = 8'h8A;
  localparam logic [15:0]       STAT_RO   = 16'h00B0;

  logic [7:0] progif_q;
  logic       class_we;

  assign class_we = cfg_wr && (cfg_dw == DW_CLASS) && cfg_be[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      progif_q <= PI_RESET;
    end else if (class_we) begin
      progif_q[0] <= cfg_wdata[8];
      progif_q[2] <= cfg_wdata[10];
    end
  end

  assign mode_pri = progif_q[0];
  assign mode_sec = progif_q[2];

  for (genvar i = 0; i < NBAR; i++) begin : g_bar
    localparam logic [15:0]       MSK   = 16'hFFFF << bar_lg2(i);
    localparam logic [CFG_AW-1:0] MY_DW = CFG_AW'(BAR_DW0 + i);
    localparam logic [15:0]       RSTV  = (i == BAR_BM) ? (BM_BASE_RST & MSK) : 16'h0000;
    logic [15:0] nxt;
    logic        we;

    assign we = cfg_wr && (cfg_dw == MY_DW) && (cfg_be[1:0] != 2'b00);

    always_comb begin
      nxt = bar_base[i];
      if (cfg_be[0]) nxt[7:0]  = cfg_wdata[7:0];
      if (cfg_be[1]) nxt[15:8] = cfg_wdata[15:8];
      nxt = nxt & MSK;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bar_base[i] <= RSTV;
        bar_ok[i]   <= (i == BAR_BM);
      end else if (we) begin
        bar_base[i] <= nxt;
        bar_ok[i]   <= 1'b1;
      end
    end
  end

  logic [CFG_AW-1:0] bar_rel;
  assign bar_rel = cfg_dw - CFG_AW'(BAR_DW0);

  always_comb begin
    cfg_rdata = 32'h0;
    if (cfg_dw == DW_ID) begin
      cfg_rdata = DEV_ID;
    end else if (cfg_dw == DW_STAT) begin
      cfg_rdata = {STAT_RO, 16'h0000};
    end else if (cfg_dw == DW_CLASS) begin
      cfg_rdata = {8'h01, 8'h01, progif_q, REV};
    end else if (cfg_dw >= CFG_AW'(BAR_DW0) && cfg_dw < CFG_AW'(BAR_DW0 + NBAR)) begin
      cfg_rdata = {16'h0000, bar_base[bar_rel[2:0]] | 16'h0001};
    end
  end
endmodule

// File: rtl/ide_io_decode.sv
module ide_io_decode
  import ide_dec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_valid,
  input  logic [15:0]     io_addr,
  input  logic            mode_pri,
  input  logic            mode_sec,
  input  bar_arr_t        bar_base,
  input  logic [NBAR-1:0] bar_ok,
  output sel_t            sel_q,
  output logic [3:0]      off_q
);
  sel_t       hits;
  sel_t       sel_d;
  logic [1:0] mode_ch;

  assign mode_ch = {mode_sec, mode_pri};

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    localparam int          CMD_BAR = 2 * ch;
    localparam int          CTL_BAR = 2 * ch + 1;
    localparam int          CMD_BIT = SEL_PCMD - 2 * ch;
    localparam int          CTL_BIT = SEL_PCTL - 2 * ch;
    localparam logic [15:0] LCMD    = (ch == 0) ? LEG_PCMD : LEG_SCMD;
    localparam logic [15:0] LCTL    = (ch == 0) ? LEG_PCTL : LEG_SCTL;

    always_comb begin
      if (mode_ch[ch]) begin
        hits[CMD_BIT] = bar_ok[CMD_BAR] && win_hit(io_addr, bar_base[CMD_BAR], bar_lg2(CMD_BAR));
        hits[CTL_BIT] = bar_ok[CTL_BAR] && win_hit(io_addr, bar_base[CTL_BAR], bar_lg2(CTL_BAR));
      end else begin
        hits[CMD_BIT] = win_hit(io_addr, LCMD, bar_lg2(CMD_BAR));
        hits[CTL_BIT] = (io_addr == LCTL);
      end
    end
  end

  assign hits[SEL_BM] = bar_ok[BAR_BM] && win_hit(io_addr, bar_base[BAR_BM], bar_lg2(BAR_BM));
  assign sel_d        = io_valid ? pick_one(hits) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      off_q <= 4'h0;
    end else begin
      sel_q <= sel_d;
      off_q <= io_addr[3:0] & off_mask(sel_d);
    end
  end
endmodule

// File: rtl/ide_irq_route.sv
module ide_irq_route (
  input  logic mode_pri,
  input  logic mode_sec,
  input  logic irq_pri_in,
  input  logic irq_sec_in,
  output logic irq_pri_legacy,
  output logic irq_sec_legacy,
  output logic irq_pci
);
  assign irq_pri_legacy = irq_pri_in && !mode_pri;
  assign irq_sec_legacy = irq_sec_in && !mode_sec;
  assign irq_pci        = (irq_pri_in && mode_pri) || (irq_sec_in && mode_sec);
endmodule

// File: rtl/ide_mode_decoder.sv
module ide_mode_decoder
  import ide_dec_pkg::*;
#(
  parameter int          CFG_AW      = 6,
  parameter logic [31:0] DEV_ID      = 32'h5A17_1D3C,
  parameter logic [7:0]  REV         = 8'hA3,
  parameter logic [15:0] BM_BASE_RST = 16'hFF60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_dw,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              io_valid,
  input  logic [15:0]       io_addr,
  output logic              sel_pri_cmd,
  output logic              sel_pri_ctl,
  output logic              sel_sec_cmd,
  output logic              sel_sec_ctl,
  output logic              sel_bm,
  output logic [3:0]        sel_offset,
  input  logic              irq_pri_in,
  input  logic              irq_sec_in,
  output logic              irq_pri_legacy,
  output logic              irq_sec_legacy,
  output logic              irq_pci
);
  logic            mode_pri;
  logic            mode_sec;
  bar_arr_t        bar_base;
  logic [NBAR-1:0] bar_ok;
  sel_t            sel_vec;
  logic [15:0]     bm_base;

  ide_cfg_regs #(
    .CFG_AW(CFG_AW), .DEV_ID(DEV_ID), .REV(REV), .BM_BASE_RST(BM_BASE_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mode_pri(mode_pri),
    .mode_sec(mode_sec), .bar_base(bar_base), .bar_ok(bar_ok)
  );

  ide_io_decode u_dec (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_addr(io_addr),
    .mode_pri(mode_pri), .mode_sec(mode_sec), .bar_base(bar_base), .bar_ok(bar_ok),
    .sel_q(sel_vec), .off_q(sel_offset)
  );

  ide_irq_route u_irq (
    .mode_pri(mode_pri), .mode_sec(mode_sec), .irq_pri_in(irq_pri_in),
    .irq_sec_in(irq_sec_in), .irq_pri_legacy(irq_pri_legacy),
    .irq_sec_legacy(irq_sec_legacy), .irq_pci(irq_pci)
  );

  assign bm_base     = bar_base[BAR_BM];
  assign sel_bm      = sel_vec[SEL_BM];
  assign sel_pri_cmd = sel_vec[SEL_PCMD];
  assign sel_pri_ctl = sel_vec[SEL_PCTL];
  assign sel_sec_cmd = sel_vec[SEL_SCMD];
  assign sel_sec_ctl = sel_vec[SEL_SCTL];
endmodule

// File: rtl/ide_mode_decoder_chk.sv
module ide_mode_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [5:0]  cfg_dw,
  input logic [3:0]  cfg_be,
  input logic        io_valid,
  input logic [15:0] io_addr,
  input logic        mode_pri,
  input logic        mode_sec,
  input logic [15:0] bm_base,
  input logic [4:0]  sel_vec,
  input logic        sel_pri_cmd,
  input logic        irq_pri_legacy,
  input logic        irq_sec_legacy
);
  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));

  // R7
  idle_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |=> (sel_vec == 5'b0));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr || cfg_dw != 6'd2 || !cfg_be[1]) |=> ($stable(mode_pri) && $stable(mode_sec)));

  // R3
  legacy_pri_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !mode_pri && io_addr[15:3] == 13'h003E && io_addr[15:4] != bm_base[15:4])
    |=> sel_pri_cmd);

  // R9
  pri_native_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_pri |-> !irq_pri_legacy);

  // R9
  sec_native_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sec |-> !irq_sec_legacy);
endmodule

bind ide_mode_decoder ide_mode_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
  .io_valid(io_valid), .io_addr(io_addr), .mode_pri(mode_pri), .mode_sec(mode_sec),
  .bm_base(bm_base), .sel_vec(sel_vec), .sel_pri_cmd(sel_pri_cmd),
  .irq_pri_legacy(irq_pri_legacy), .irq_sec_legacy(irq_sec_legacy)
);

// File: tb/tb_ide_mode_decoder.sv
module tb_ide_mode_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        io_valid = 1'b0;
  logic [15:0] io_addr = '0;
  logic        sel_pri_cmd, sel_pri_ctl, sel_sec_cmd, sel_sec_ctl, sel_bm;
  logic [3:0]  sel_offset;
  logic        irq_pri_in = 1'b0;
  logic        irq_sec_in = 1'b0;
  logic        irq_pri_legacy, irq_sec_legacy, irq_pci;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rd;

  always #4 clk = ~clk;   // 125 MHz

  ide_mode_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_valid(io_valid), .io_addr(io_addr),
    .sel_pri_cmd(sel_pri_cmd), .sel_pri_ctl(sel_pri_ctl), .sel_sec_cmd(sel_sec_cmd),
    .sel_sec_ctl(sel_sec_ctl), .sel_bm(sel_bm), .sel_offset(sel_offset),
    .irq_pri_in(irq_pri_in), .irq_sec_in(irq_sec_in), .irq_pri_legacy(irq_pri_legacy),
    .irq_sec_legacy(irq_sec_legacy), .irq_pci(irq_pci)
  );

  // strobe order {bm, pri_cmd, pri_ctl, sec_cmd, sec_ctl}
  localparam logic [4:0] S_NONE = 5'b00000, S_BM = 5'b10000, S_PCMD = 5'b01000,
                         S_PCTL = 5'b00100, S_SCMD = 5'b00010, S_SCTL = 5'b00001;

  // {address, strobes, offset} with both channels in compatibility mode
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {16'h01F0, S_PCMD, 4'h0}, {16'h01F7, S_PCMD, 4'h7}, {16'h01EF, S_NONE, 4'h0},
    {16'h01F8, S_NONE, 4'h0}, {16'h03F6, S_PCTL, 4'h2}, {16'h03F7, S_NONE, 4'h0},
    {16'h0170, S_SCMD, 4'h0}, {16'h0175, S_SCMD, 4'h5}, {16'h0376, S_SCTL, 4'h2},
    {16'hFF60, S_BM,   4'h0}, {16'hFF6F, S_BM,   4'hF}, {16'hFF68, S_BM,   4'h8},
    {16'hFF70, S_NONE, 4'h0}, {16'h0000, S_NONE, 4'h0}
  };

  function automatic logic [4:0] sel_now();
    return {sel_bm, sel_pri_cmd, sel_pri_ctl, sel_sec_cmd, sel_sec_ctl};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [5:0] dw, output logic [31:0] d);
    @(negedge clk);
    cfg_dw = dw;
    #1 d = cfg_rdata;
  endtask

  // one access; results are read at the following falling edge
  task automatic io_acc(input logic [15:0] a);
    @(negedge clk);
    io_valid = 1'b1; io_addr = a;
    @(negedge clk);
    io_valid = 1'b0;
  endtask

  task automatic io_chk(input string req, input logic [15:0] a,
                        input logic [4:0] s, input logic [3:0] o);
    io_acc(a);
    chk(req, {23'h0, sel_now(), sel_offset}, {23'h0, s, o});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk("R1 strobes", {27'h0, sel_now()}, 32'h0);
    cfg_read(6'd0, rd); chk("R1 id", rd, 32'h5A17_1D3C);
    cfg_read(6'd1, rd); chk("R1 status", rd, 32'h00B0_0000);
    cfg_read(6'd2, rd); chk("R1 class", rd, 32'h0101_8AA3);
    cfg_read(6'd8, rd); chk("R1 R10 bm base", rd, 32'h0000_FF61);
    cfg_read(6'd4, rd); chk("R1 bar0", rd, 32'h0000_0001);
    cfg_read(6'd7, rd); chk("R1 bar3", rd, 32'h0000_0001);

    // R3 R4 R6 R7 R8 compatibility decode table
    for (int i = 0; i < NV; i++) begin
      io_chk("R3/R4/R6 table", VEC[i][24:9], VEC[i][8:4], VEC[i][3:0]);
    end

    // R7 idle: address on a legacy port without io_valid
    @(negedge clk); io_addr = 16'h0170;
    @(negedge clk);
    chk("R7 idle", {27'h0, sel_now()}, 32'h0);

    // R2 only bits 8 and 10 writable, only with byte enable 1
    cfg_write(6'd2, 4'b1111, 32'hFFFF_FFFF);
    cfg_read(6'd2, rd); chk("R2 set", rd, 32'h0101_8FA3);
    cfg_write(6'd2, 4'b1101, 32'h0000_0000);
    cfg_read(6'd2, rd); chk("R2 no be1", rd, 32'h0101_8FA3);
    cfg_write(6'd2, 4'b0010, 32'h0000_0000);
    cfg_read(6'd2, rd); chk("R2 clear", rd, 32'h0101_8AA3);

    // R11 mode write and legacy access in the same cycle
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw = 6'd2; cfg_be = 4'b0010; cfg_wdata = 32'h0000_0100;
    io_valid = 1'b1; io_addr = 16'h01F2;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; io_valid = 1'b0;
    chk("R11 old mode", {23'h0, sel_now(), sel_offset}, {23'h0, S_PCMD, 4'h2});
    // R5 native primary ignores legacy and unprogrammed windows
    io_chk("R5 legacy ignored", 16'h01F2, S_NONE, 4'h0);
    io_chk("R5 ctl legacy ignored", 16'h03F6, S_NONE, 4'h0);
    io_chk("R5 unprogrammed", 16'h0000, S_NONE, 4'h0);

    // R10 base read-back, R5 native windows
    cfg_write(6'd4, 4'b0011, 32'h0000_C007);
    cfg_read(6'd4, rd); chk("R10 cmd base", rd, 32'h0000_C001);
    cfg_write(6'd5, 4'b0011, 32'h0000_C00A);
    cfg_read(6'd5, rd); chk("R10 ctl base", rd, 32'h0000_C009);
    io_chk("R5 native cmd", 16'hC003, S_PCMD, 4'h3);
    io_chk("R5 native ctl", 16'hC00B, S_PCTL, 4'h3);
    io_chk("R5 past cmd window", 16'hC00C, S_NONE, 4'h0);
    io_chk("R4 secondary still legacy", 16'h0177, S_SCMD, 4'h7);

    // R9 interrupt routing: primary native, secondary legacy
    @(negedge clk); irq_pri_in = 1'b1;
    #1 chk("R9 pri native", {29'h0, irq_pri_legacy, irq_sec_legacy, irq_pci}, 32'h1);
    irq_pri_in = 1'b0; irq_sec_in = 1'b1;
    #1 chk("R9 sec legacy", {29'h0, irq_pri_legacy, irq_sec_legacy, irq_pci}, 32'h2);
    irq_sec_in = 1'b0;

    // R8 priority: secondary native command window placed on the bus-master base
    cfg_write(6'd2, 4'b0010, 32'h0000_0500);
    cfg_write(6'd6, 4'b0011, 32'h0000_FF60);
    io_chk("R8 bm wins overlap", 16'hFF64, S_BM, 4'h4);
    io_chk("R6 secondary half", 16'hFF6C, S_BM, 4'hC);
    io_chk("R5 sec legacy ignored", 16'h0376, S_NONE, 4'h0);
    io_chk("R5 sec cmd legacy ignored", 16'h0170, S_NONE, 4'h0);
    @(negedge clk); irq_sec_in = 1'b1;
    #1 chk("R9 sec native", {29'h0, irq_pri_legacy, irq_sec_legacy, irq_pci}, 32'h1);
    irq_sec_in = 1'b0;

    // R6 bus-master base moved
    cfg_write(6'd8, 4'b0011, 32'h0000_A01F);
    cfg_read(6'd8, rd); chk("R10 bm base moved", rd, 32'h0000_A011);
    io_chk("R6 new bm base", 16'hA019, S_BM, 4'h9);
    io_chk("R5 sec native cmd", 16'hFF61, S_SCMD, 4'h1);

    finish_run();
  end
endmodule